// File: doc/BRIEF.md
# SPI Master Channel with Word Counter

This block is one serial-peripheral master channel that sits behind a small word-indexed register port. Software chooses the clock polarity, the phase, the word width (8, 16 or 32 bits) and a prescale value. Words written to the transmit data register go into a transmit FIFO. A shift engine sends each word out MSB first, and the receive path puts every captured word into a receive FIFO. Software reads the words from there.

The serial clock runs at the system clock divided by 2×(divider+1). The chip-select register acts as a start/stop switch. While its bit 0 is set, the select line is held inactive and the engine stays parked. Clearing the bit asserts the select line and lets words flow. An optional word counter makes the engine clock out exactly N words with receive capture, even when there is nothing to transmit, and then stop by itself. Four sticky error flags record FIFO misuse and engine starvation. Each flag is cleared by writing a one to its bit.

Register index (reg_idx): 0 status, 1 control, 2 select, 3 clock, 4 size, 5 counter, 6 error clear, 7 transmit data, 8 receive data.

Top module: `spim_channel`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, the select register reads 1, and the status register reads 0x0200_0001. In the status register, bit 0 is transmit-not-full, bit 1 is receive-not-empty, the transmit level is in bits 10:6, the receive level is in bits 19:15 and transmit-done is bit 25.
- R2: While a word is shifting, successive spi_sclk transitions are exactly divider+1 system clocks apart. The divider is clock register bits 7:0, and bit 8 enables the serial clock.
- R3: While the engine is idle, spi_sclk sits at the clock-polarity bit (control bit 3). spi_cs_n follows select register bit 0.
- R4: While select bit 0 is 1, no serial-clock edge occurs and transmit data stays in the FIFO.
- R5: The first serial-clock edge of a transfer comes at least divider+1 system clocks after the select register is written to 0.
- R6: Control bit 0 enables transmit, bit 1 enables receive and bit 2 selects phase. In all four polarity/phase modes, a looped-back word comes back unchanged. The width comes from size register bits 30:29: code 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, and 3 acts as 8 bits. Written data is truncated to the width, and read data is zero-extended.
- R7: Writing the counter register with bit 16 set and a count N in bits 15:0, with receive on, makes the engine receive exactly N words without any transmit writes and then stop. Counter reads return bit 16 and the remaining count.
- R8: In counter mode, if transmit is on and a word starts with the transmit FIFO empty, the transmit-underrun flag (status bit 2) is set and zeros are sent.
- R9: A transmit write while the FIFO is full is dropped and sets the transmit-overrun flag (status bit 3). The level never exceeds the FIFO depth.
- R10: A receive read from an empty FIFO returns 0 and sets the receive-underrun flag (status bit 4).
- R11: A word that completes while the receive FIFO is full is discarded and sets the receive-overrun flag (status bit 5). The earlier contents are kept.
- R12: Writing a 1 to error-clear bits 1, 2, 3 or 4 clears receive overrun, receive underrun, transmit overrun or transmit underrun respectively. Writing 0 leaves the flags unchanged.
- R13: While control bit 5 (channel reset) is 1, both FIFOs are empty and transmit writes are lost. The effect holds until software clears the bit.
- R14: Transmit-done is 0 while a word is queued or shifting. It is 1 once the FIFO is empty and the last bit has left the shifter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the access |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The hardest condition to reach from the ports is a full receive FIFO with the engine still running. Without the word counter, every received word needs a transmit write, and the transmit FIFO would drain in step. The bench therefore runs the counter with transmit disabled and asks for two more words than the FIFO holds. It drives the serial input to a constant so that the overflowed contents can be recognised. Counter-mode starvation is reached the same way, with transmit enabled and nothing queued. The clock spacing is measured edge to edge after the select register is cleared.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W    = 32;
  localparam int REG_IDX_W = 4;
  localparam int PKT_W     = 16;

  typedef logic [REG_IDX_W-1:0] reg_idx_t;
  localparam reg_idx_t RI_STAT = 4'd0;
  localparam reg_idx_t RI_CTRL = 4'd1;
  localparam reg_idx_t RI_CSEL = 4'd2;
  localparam reg_idx_t RI_CLK  = 4'd3;
  localparam reg_idx_t RI_SIZE = 4'd4;
  localparam reg_idx_t RI_PKT  = 4'd5;
  localparam reg_idx_t RI_ECLR = 4'd6;
  localparam reg_idx_t RI_TXD  = 4'd7;
  localparam reg_idx_t RI_RXD  = 4'd8;

  // control register, tx_on is bit 0
  typedef struct packed {
    logic hs;
    logic swrst;
    logic slv;
    logic cpol;
    logic cpha;
    logic rx_on;
    logic tx_on;
  } ctrl_t;

  typedef struct packed {
    logic rxovr;
    logic rxund;
    logic txovr;
    logic txund;
  } err_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LEAD, ENG_SHIFT} eng_state_e;

  function automatic logic [5:0] size_bits(input logic [1:0] code);
    case (code)
      2'd1:    return 6'd16;
      2'd2:    return 6'd32;
      default: return 6'd8;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] word_mask(input logic [5:0] nb);
    if (nb == 6'd32) return '1;
    return (DATA_W'(1) << nb) - DATA_W'(1);
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic                             push,
  input  logic [WIDTH-1:0]                 wdata,
  input  logic                             pop,
  output logic [WIDTH-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]       level,
  output logic                             full,
  output logic                             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             do_push, do_pop;

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign level   = lvl_q;
  assign head    = mem[rptr_q];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    lvl_n  = lvl_q;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      lvl_n  = '0;
    end else begin
      if (do_push) wptr_n = bump(wptr_q);
      if (do_pop)  rptr_n = bump(rptr_q);
      case ({do_push, do_pop})
        2'b10:   lvl_n = lvl_q + LVL_W'(1);
        2'b01:   lvl_n = lvl_q - LVL_W'(1);
        default: lvl_n = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      lvl_q  <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end
endmodule

// File: rtl/spim_prescale.sv
module spim_prescale #(
  parameter int PSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSR_W-1:0] psr,
  output logic             tick
);
  logic [PSR_W-1:0] cnt_q, cnt_n;

  assign tick = run && (cnt_q == psr);

  always_comb begin
    if (!run || cnt_q == psr) cnt_n = '0;
    else                      cnt_n = cnt_q + PSR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              start,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [5:0]        nbits,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int EC_W = $clog2(2 * DATA_W);

  eng_state_e        st_q, st_n;
  logic              sclk_q, sclk_n, mosi_q, mosi_n, cph_q, cph_n;
  logic [DATA_W-1:0] tx_q, tx_n, rx_q, rx_n, load_sh;
  logic [EC_W-1:0]   ec_q, ec_n;
  logic [5:0]        nb_q, nb_n;
  logic [6:0]        last_idx;

  assign load_sh  = tx_word << (6'd32 - nbits);
  assign last_idx = {nb_q, 1'b0} - 7'd1;
  assign sclk     = sclk_q;
  assign mosi     = mosi_q;
  assign idle     = (st_q == ENG_IDLE);
  assign rx_word  = rx_n & word_mask(nb_q);

  always_comb begin
    st_n   = st_q;
    sclk_n = sclk_q;
    mosi_n = mosi_q;
    cph_n  = cph_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    ec_n   = ec_q;
    nb_n   = nb_q;
    done   = 1'b0;
    if (kill) begin
      st_n   = ENG_IDLE;
      sclk_n = cpol;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          sclk_n = cpol;
          if (start) begin
            st_n  = ENG_LEAD;
            nb_n  = nbits;
            cph_n = cpha;
            ec_n  = '0;
            if (!cpha) begin
              mosi_n = load_sh[DATA_W-1];
              tx_n   = load_sh << 1;
            end else begin
              tx_n = load_sh;
            end
          end
        end
        ENG_LEAD: if (tick) st_n = ENG_SHIFT;
        ENG_SHIFT: begin
          if (tick) begin
            sclk_n = ~sclk_q;
            ec_n   = ec_q + EC_W'(1);
            // leading edge samples in phase 0, trailing edge in phase 1
            if (!ec_q[0] ^ cph_q) begin
              rx_n = {rx_q[DATA_W-2:0], miso};
            end else begin
              mosi_n = tx_q[DATA_W-1];
              tx_n   = tx_q << 1;
            end
            if ({1'b0, ec_q} == last_idx) begin
              st_n = ENG_IDLE;
              done = 1'b1;
            end
          end
        end
        default: st_n = ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      cph_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      ec_q   <= '0;
      nb_q   <= 6'd8;
    end else begin
      st_q   <= st_n;
      sclk_q <= sclk_n;
      mosi_q <= mosi_n;
      cph_q  <= cph_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      ec_q   <= ec_n;
      nb_q   <= nb_n;
    end
  end
endmodule

// File: rtl/spim_channel.sv
module spim_channel
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int PSR_W      = 8,
  parameter int RXLVL_POS  = 15,
  parameter int TXDONE_POS = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 spi_sclk,
  output logic                 spi_mosi,
  input  logic                 spi_miso,
  output logic                 spi_cs_n
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  ctrl_t             ctrl_q, ctrl_n;
  err_t              err_q, err_n, err_set, err_clr;
  logic              clken_q, clken_n, csel_q, csel_n, pkten_q, pkten_n;
  logic [PSR_W-1:0]  psr_q, psr_n;
  logic [1:0]        csz_q, csz_n, bsz_q, bsz_n;
  logic [PKT_W-1:0]  rem_q, rem_n;

  logic              wr, rd, tx_wr_req, rx_rd_req;
  logic [5:0]        nbits;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic [DATA_W-1:0] tx_head, rx_head, eng_tx_word, eng_rx_word, stat;
  logic              eng_idle, eng_done, eng_start, eng_want, tick;
  logic              tx_push, tx_pop, rx_push, rx_pop;

  assign wr        = reg_en && reg_we;
  assign rd        = reg_en && !reg_we;
  assign tx_wr_req = wr && (reg_idx == RI_TXD);
  assign rx_rd_req = rd && (reg_idx == RI_RXD);
  assign nbits     = size_bits(csz_q);

  assign tx_push = tx_wr_req && !tx_full;
  assign rx_pop  = rx_rd_req && !rx_empty;

  // engine launch
  assign eng_want  = pkten_q ? ((rem_q != '0) && ctrl_q.rx_on)
                             : (ctrl_q.tx_on && !tx_empty);
  assign eng_start = !csel_q && clken_q && !ctrl_q.swrst && eng_idle && eng_want;
  assign tx_pop      = eng_start && ctrl_q.tx_on && !tx_empty;
  assign eng_tx_word = tx_pop ? tx_head : '0;
  assign rx_push     = eng_done && ctrl_q.rx_on && !rx_full;

  always_comb begin
    err_set       = '0;
    err_set.txovr = tx_wr_req && tx_full;
    err_set.rxund = rx_rd_req && rx_empty;
    err_set.txund = eng_start && pkten_q && ctrl_q.tx_on && tx_empty;
    err_set.rxovr = eng_done && ctrl_q.rx_on && rx_full;
    err_clr       = '0;
    if (wr && reg_idx == RI_ECLR) begin
      err_clr.rxovr = reg_wdata[1];
      err_clr.rxund = reg_wdata[2];
      err_clr.txovr = reg_wdata[3];
      err_clr.txund = reg_wdata[4];
    end
  end

  always_comb begin
    ctrl_n  = ctrl_q;
    clken_n = clken_q;
    psr_n   = psr_q;
    csz_n   = csz_q;
    bsz_n   = bsz_q;
    csel_n  = csel_q;
    pkten_n = pkten_q;
    rem_n   = rem_q;
    err_n   = (err_q & ~err_clr) | err_set;
    if (eng_start && pkten_q) rem_n = rem_q - PKT_W'(1);
    if (wr) begin
      case (reg_idx)
        RI_CTRL: ctrl_n = ctrl_t'(reg_wdata[6:0]);
        RI_CLK: begin
          psr_n   = reg_wdata[PSR_W-1:0];
          clken_n = reg_wdata[PSR_W];
        end
        RI_SIZE: begin
          csz_n = reg_wdata[30:29];
          bsz_n = reg_wdata[18:17];
        end
        RI_CSEL: csel_n = reg_wdata[0];
        RI_PKT: begin
          pkten_n = reg_wdata[PKT_W];
          rem_n   = reg_wdata[PKT_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      clken_q <= 1'b0;
      psr_q   <= '0;
      csz_q   <= '0;
      bsz_q   <= '0;
      csel_q  <= 1'b1;
      pkten_q <= 1'b0;
      rem_q   <= '0;
      err_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_n;
      clken_q <= clken_n;
      psr_q   <= psr_n;
      csz_q   <= csz_n;
      bsz_q   <= bsz_n;
      csel_q  <= csel_n;
      pkten_q <= pkten_n;
      rem_q   <= rem_n;
      err_q   <= err_n;
    end
  end

  always_comb begin
    stat                       = '0;
    stat[0]                    = !tx_full;
    stat[1]                    = !rx_empty;
    stat[2]                    = err_q.txund;
    stat[3]                    = err_q.txovr;
    stat[4]                    = err_q.rxund;
    stat[5]                    = err_q.rxovr;
    stat[6 +: LVL_W]           = tx_lvl;
    stat[RXLVL_POS +: LVL_W]   = rx_lvl;
    stat[TXDONE_POS]           = tx_empty && eng_idle;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      RI_STAT: reg_rdata = stat;
      RI_CTRL: reg_rdata[6:0] = ctrl_q;
      RI_CSEL: reg_rdata[0] = csel_q;
      RI_CLK: begin
        reg_rdata[PSR_W-1:0] = psr_q;
        reg_rdata[PSR_W]     = clken_q;
      end
      RI_SIZE: begin
        reg_rdata[30:29] = csz_q;
        reg_rdata[18:17] = bsz_q;
      end
      RI_PKT: begin
        reg_rdata[PKT_W-1:0] = rem_q;
        reg_rdata[PKT_W]     = pkten_q;
      end
      RI_RXD: reg_rdata = rx_empty ? '0 : rx_head;
      default: reg_rdata = '0;
    endcase
  end

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(ctrl_q.swrst),
    .push(tx_push), .wdata(reg_wdata & word_mask(nbits)),
    .pop(tx_pop), .head(tx_head), .level(tx_lvl),
    .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(ctrl_q.swrst),
    .push(rx_push), .wdata(eng_rx_word),
    .pop(rx_pop), .head(rx_head), .level(rx_lvl),
    .full(rx_full), .empty(rx_empty)
  );

  spim_prescale #(.PSR_W(PSR_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(!eng_idle), .psr(psr_q), .tick(tick)
  );

  spim_shifter u_eng (
    .clk(clk), .rst_n(rst_n), .kill(ctrl_q.swrst), .start(eng_start),
    .tick(tick), .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .nbits(nbits),
    .tx_word(eng_tx_word), .miso(spi_miso), .sclk(spi_sclk),
    .mosi(spi_mosi), .idle(eng_idle), .done(eng_done), .rx_word(eng_rx_word)
  );

  assign spi_cs_n = csel_q;
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_sclk,
  input logic             spi_cs_n,
  input logic             eng_idle,
  input logic             cpol,
  input logic             swrst,
  input logic             tx_wr_req,
  input logic             tx_full,
  input logic             rx_rd_req,
  input logic             rx_empty,
  input logic             txovr_flag,
  input logic             rxund_flag,
  input logic [LVL_W-1:0] tx_lvl,
  input logic [LVL_W-1:0] rx_lvl
);
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_idle) |-> (spi_sclk == $past(cpol)));

  // R4
  parked_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && eng_idle) |=> eng_idle);

  // R9
  tx_overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_req && tx_full && !swrst) |=> txovr_flag);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= LVL_W'(DEPTH));

  // R10
  rx_underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_req && rx_empty) |=> rxund_flag);

  // R11
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl <= LVL_W'(DEPTH));
endmodule

bind spim_channel spim_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .eng_idle(eng_idle), .cpol(ctrl_q.cpol), .swrst(ctrl_q.swrst),
  .tx_wr_req(tx_wr_req), .tx_full(tx_full), .rx_rd_req(rx_rd_req),
  .rx_empty(rx_empty), .txovr_flag(err_q.txovr), .rxund_flag(err_q.rxund),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl)
);

// File: tb/sim_spim_channel.sv
module sim_spim_channel;
  logic        clk, rst_n, reg_en, reg_we, spi_sclk, spi_mosi, spi_cs_n;
  logic [3:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        loop_en, miso_val;
  int          checks, fails, cyc;

  wire spi_miso = loop_en ? spi_mosi : miso_val;

  spim_channel u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {cpol, cpha, size[1:0], tx data, expected rx}
  localparam logic [67:0] VEC [9] = '{
    {1'b0, 1'b0, 2'd0, 32'h0000_00A5, 32'h0000_00A5},
    {1'b0, 1'b1, 2'd0, 32'h1234_5669, 32'h0000_0069},
    {1'b1, 1'b0, 2'd1, 32'hDEAD_BEEF, 32'h0000_BEEF},
    {1'b1, 1'b1, 2'd1, 32'h0000_8001, 32'h0000_8001},
    {1'b0, 1'b0, 2'd2, 32'hC0FF_EE11, 32'hC0FF_EE11},
    {1'b1, 1'b1, 2'd2, 32'h8000_0001, 32'h8000_0001},
    {1'b0, 1'b1, 2'd2, 32'h7F00_00FE, 32'h7F00_00FE},
    {1'b1, 1'b0, 2'd0, 32'hFFFF_FF3C, 32'h0000_003C},
    {1'b0, 1'b0, 2'd3, 32'hABCD_1299, 32'h0000_0099}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_idx = idx;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(4'd0, s);
      if (int'(s[19:15]) >= n) break;
    end
  endtask

  logic [31:0] v, s;
  int          n1, gap;
  logic        prev, moved;

  initial begin
    checks = 0; fails = 0; cyc = 0;
    reg_en = 0; reg_we = 0; reg_idx = 0; reg_wdata = 0;
    loop_en = 1'b1; miso_val = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1 cs_n", 32'(spi_cs_n), 32'd1);
    chk(spi_sclk == 1'b0, "R1 sclk", 32'(spi_sclk), 32'd0);
    rd(4'd0, v); chk(v == 32'h0200_0001, "R1 status", v, 32'h0200_0001);
    rd(4'd2, v); chk(v == 32'd1, "R1 select", v, 32'd1);

    // R3 idle polarity and select pin
    wr(4'd1, 32'h8);
    @(negedge clk);
    chk(spi_sclk == 1'b1, "R3 idle cpol1", 32'(spi_sclk), 32'd1);
    wr(4'd2, 32'h0);
    chk(spi_cs_n == 1'b0, "R3 cs asserted", 32'(spi_cs_n), 32'd0);
    wr(4'd2, 32'h1);
    chk(spi_cs_n == 1'b1, "R3 cs released", 32'(spi_cs_n), 32'd1);

    // R4 parked while select inactive
    wr(4'd1, 32'h3);
    wr(4'd4, 32'h0);
    wr(4'd3, 32'h103);
    wr(4'd7, 32'h55);
    prev = spi_sclk; moved = 1'b0;
    repeat (40) begin @(negedge clk); if (spi_sclk != prev) moved = 1'b1; end
    chk(!moved, "R4 no sclk edge", 32'(moved), 32'd0);
    rd(4'd0, v);
    chk(v[10:6] == 5'd1, "R4 tx level kept", 32'(v[10:6]), 32'd1);
    chk(v[25] == 1'b0, "R14 done low while queued", 32'(v[25]), 32'd0);

    // R5 lead time, R2 half period
    wr(4'd2, 32'h0);
    n1 = 0; prev = spi_sclk;
    while (spi_sclk == prev && n1 < 300) begin @(negedge clk); n1++; end
    chk(n1 >= 4 && n1 < 300, "R5 first edge delay", 32'(n1), 32'd4);
    gap = 0; prev = spi_sclk;
    while (spi_sclk == prev && gap < 300) begin @(negedge clk); gap++; end
    chk(gap == 4, "R2 half period", 32'(gap), 32'd4);
    rd(4'd0, v);
    chk(v[25] == 1'b0, "R14 done low while shifting", 32'(v[25]), 32'd0);
    wait_rx(1);
    rd(4'd8, v); chk(v == 32'h55, "R6 loopback psr3", v, 32'h55);
    repeat (10) @(negedge clk);
    rd(4'd0, v); chk(v[25] == 1'b1, "R14 done after shift", 32'(v[25]), 32'd1);
    wr(4'd2, 32'h1);

    // R6 vector table: modes and word sizes
    wr(4'd3, 32'h101);
    for (int i = 0; i < 9; i++) begin
      logic [67:0] e;
      e = VEC[i];
      wr(4'd1, {28'd0, e[67], e[66], 2'b11});
      wr(4'd4, {1'b0, e[65:64], 10'd0, e[65:64], 17'd0});
      wr(4'd7, e[63:32]);
      wr(4'd2, 32'h0);
      wait_rx(1);
      rd(4'd8, v);
      chk(v == e[31:0], $sformatf("R6 vector %0d", i), v, e[31:0]);
      wr(4'd2, 32'h1);
    end

    // R7 counter mode, receive only
    loop_en = 1'b0; miso_val = 1'b1;
    wr(4'd1, 32'h2);
    wr(4'd4, 32'h0);
    wr(4'd5, 32'h0001_0003);
    wr(4'd2, 32'h0);
    wait_rx(3);
    repeat (100) @(negedge clk);
    rd(4'd0, v);
    chk(v[19:15] == 5'd3, "R7 exact word count", 32'(v[19:15]), 32'd3);
    chk(v[2] == 1'b0, "R7 no underrun with tx off", 32'(v[2]), 32'd0);
    rd(4'd5, v); chk(v == 32'h0001_0000, "R7 remaining zero", v, 32'h0001_0000);
    for (int i = 0; i < 3; i++) begin
      rd(4'd8, v); chk(v == 32'hFF, "R7 captured word", v, 32'hFF);
    end

    // R8 counter mode starved transmit
    miso_val = 1'b0;
    wr(4'd1, 32'h3);
    wr(4'd5, 32'h0001_0002);
    wait_rx(2);
    rd(4'd0, v); chk(v[2] == 1'b1, "R8 tx underrun flag", 32'(v[2]), 32'd1);
    rd(4'd8, v); chk(v == 32'h0, "R8 zero data", v, 32'h0);
    rd(4'd8, v);
    // R12 write-one-to-clear
    wr(4'd6, 32'h0);
    rd(4'd0, v); chk(v[2] == 1'b1, "R12 zero write keeps", 32'(v[2]), 32'd1);
    wr(4'd6, 32'h10);
    rd(4'd0, v); chk(v[2] == 1'b0, "R12 clear tx underrun", 32'(v[2]), 32'd0);
    wr(4'd5, 32'h0);

    // R9 transmit overrun
    wr(4'd2, 32'h1);
    for (int i = 0; i < 17; i++) wr(4'd7, 32'(i));
    rd(4'd0, v);
    chk(v[10:6] == 5'd16, "R9 level capped", 32'(v[10:6]), 32'd16);
    chk(v[3] == 1'b1, "R9 overrun flag", 32'(v[3]), 32'd1);

    // R13 channel reset
    wr(4'd1, 32'h23);
    rd(4'd0, v); chk(v[10:6] == 5'd0, "R13 tx flushed", 32'(v[10:6]), 32'd0);
    wr(4'd7, 32'h1);
    rd(4'd0, v); chk(v[10:6] == 5'd0, "R13 write lost in reset", 32'(v[10:6]), 32'd0);
    wr(4'd1, 32'h3);
    rd(4'd0, v); chk(v[10:6] == 5'd0, "R13 still empty after release", 32'(v[10:6]), 32'd0);
    wr(4'd6, 32'h8);
    rd(4'd0, v); chk(v[3] == 1'b0, "R12 clear tx overrun", 32'(v[3]), 32'd0);

    // R10 receive underrun
    rd(4'd8, v); chk(v == 32'h0, "R10 empty read zero", v, 32'h0);
    rd(4'd0, v); chk(v[4] == 1'b1, "R10 underrun flag", 32'(v[4]), 32'd1);
    wr(4'd6, 32'h4);

    // R11 receive overrun via counter
    miso_val = 1'b1;
    wr(4'd1, 32'h2);
    wr(4'd3, 32'h100);
    wr(4'd2, 32'h0);
    wr(4'd5, 32'h0001_0012);
    for (int i = 0; i < 3000; i++) begin
      rd(4'd5, s);
      if (s == 32'h0001_0000) break;
    end
    repeat (60) @(negedge clk);
    rd(4'd0, v);
    chk(v[19:15] == 5'd16, "R11 rx level capped", 32'(v[19:15]), 32'd16);
    chk(v[5] == 1'b1, "R11 overrun flag", 32'(v[5]), 32'd1);
    rd(4'd8, v); chk(v == 32'hFF, "R11 old data kept", v, 32'hFF);

    summary();
    $finish;
  end
endmodule